// File: doc/BRIEF.md
# Integer ALU with Shifter and Compare

This block is the integer execution unit of a small RISC core. Each cycle it takes two 32-bit register operands, a 16-bit immediate, a 5-bit immediate and an operation code. It produces one 32-bit result. The result comes from one of several operation families:

- add and subtract
- bitwise logic on the low half or the upper half
- rotates and shifts
- set-on-compare
- multiply, giving either the low or the high product word

Immediates are widened inside the block, and the way each one is widened depends on the operation. Decode logic upstream only has to pass the raw fields through.

The arithmetic and multiply paths are combinational. A register can be placed at the output, controlled by a parameter that is on by default. With that register, the result of the operands presented on one rising edge appears on the output after that edge. Add and subtract wrap modulo 2^32 and raise no flags. Subtract-immediate reuses the adder, negating the sign-extended immediate.

Top module: `ialu_core`

## Requirements
- R1: While reset is low the result is 0; with the output register enabled, the result for the inputs sampled at a rising edge is visible after that edge and stays until the next one.
- R2: ADD (0x00) gives a+b and SUB (0x02) gives a-b, modulo 2^32. ADDI (0x01) adds the sign-extended 16-bit immediate (0x8000 → 0xFFFF8000, 0x7000 → 0x00007000). SUBI (0x03) subtracts that same sign-extended value.
- R3: AND (0x04), OR (0x07), XOR (0x0A) and NOR (0x0D) combine a with b. ANDI (0x05), ORI (0x08) and XORI (0x0B) combine a with the zero-extended 16-bit immediate.
- R4: ANDHI (0x06), ORHI (0x09) and XORHI (0x0C) combine a with the immediate placed in bits 31..16, with zeros in bits 15..0.
- R5: Register-count shifts and rotates use only b[4:0]; b[31:5] has no effect. The immediate-count forms use the 5-bit immediate.
- R6: ROL (0x0E) and ROLI (0x0F) rotate a left, and ROR (0x10) rotates a right, circularly. A right rotate by n equals ROLI by 32-n.
- R7: SLL (0x11) and SLLI (0x12) shift left with zero fill. SRL (0x13) and SRLI (0x14) shift right with zero fill. SRA (0x15) and SRAI (0x16) shift right and fill with copies of a[31].
- R8: The register compares give exactly 0 or 1: CMPEQ (0x17) for a==b, CMPNE (0x19) for a!=b, CMPGE (0x1B) for signed a>=b, CMPGEU (0x1D) for unsigned a>=b, CMPLT (0x1F) for signed a<b, and CMPLTU (0x21) for unsigned a<b.
- R9: The immediate compares CMPEQI (0x18), CMPNEI (0x1A), CMPGEI (0x1C) and CMPLTI (0x20) use the sign-extended immediate. CMPGEUI (0x1E) and CMPLTUI (0x22) use the zero-extended immediate.
- R10: MUL (0x23) gives bits 31..0 of a×b. MULI (0x24) gives bits 31..0 of a×(sign-extended immediate).
- R11: The high-word multiplies give bits 63..32 of the product: MULHSS (0x25) treats both operands as signed, MULHSU (0x26) treats a as signed and b as unsigned, and MULHUU (0x27) treats both as unsigned.
- R12: Any operation code from 0x28 to 0x3F gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 6 | Operation code |
| a_i | input | 32 | First register operand |
| b_i | input | 32 | Second register operand, or the shift/rotate count in bits 4..0 |
| imm16_i | input | 16 | Raw 16-bit immediate |
| imm5_i | input | 5 | Immediate shift/rotate count |
| result_o | output | 32 | Operation result |

## Verification
Every result is due exactly one rising edge after its operands and code are applied, whatever the operation, because the single output register is the only state on the path. The bench changes the inputs on a falling edge and reads the result on the next falling edge, half a period after the register has updated. This keeps every comparison clear of the edge. The properties use the same one-cycle relation, checking the value after an edge against the inputs sampled at that edge.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

    typedef enum logic [5:0] {
        OP_ADD     = 6'h00,
        OP_ADDI    = 6'h01,
        OP_SUB     = 6'h02,
        OP_SUBI    = 6'h03,
        OP_AND     = 6'h04,
        OP_ANDI    = 6'h05,
        OP_ANDHI   = 6'h06,
        OP_OR      = 6'h07,
        OP_ORI     = 6'h08,
        OP_ORHI    = 6'h09,
        OP_XOR     = 6'h0A,
        OP_XORI    = 6'h0B,
        OP_XORHI   = 6'h0C,
        OP_NOR     = 6'h0D,
        OP_ROL     = 6'h0E,
        OP_ROLI    = 6'h0F,
        OP_ROR     = 6'h10,
        OP_SLL     = 6'h11,
        OP_SLLI    = 6'h12,
        OP_SRL     = 6'h13,
        OP_SRLI    = 6'h14,
        OP_SRA     = 6'h15,
        OP_SRAI    = 6'h16,
        OP_CMPEQ   = 6'h17,
        OP_CMPEQI  = 6'h18,
        OP_CMPNE   = 6'h19,
        OP_CMPNEI  = 6'h1A,
        OP_CMPGE   = 6'h1B,
        OP_CMPGEI  = 6'h1C,
        OP_CMPGEU  = 6'h1D,
        OP_CMPGEUI = 6'h1E,
        OP_CMPLT   = 6'h1F,
        OP_CMPLTI  = 6'h20,
        OP_CMPLTU  = 6'h21,
        OP_CMPLTUI = 6'h22,
        OP_MUL     = 6'h23,
        OP_MULI    = 6'h24,
        OP_MULHSS  = 6'h25,
        OP_MULHSU  = 6'h26,
        OP_MULHUU  = 6'h27
    } alu_op_e;

    localparam int unsigned OP_CODES_USED = 40;

    typedef enum logic [1:0] {
        LF_AND,
        LF_OR,
        LF_XOR,
        LF_NOR
    } logic_fn_e;

    typedef enum logic [2:0] {
        SK_SLL,
        SK_SRL,
        SK_SRA,
        SK_ROL,
        SK_ROR
    } shift_kind_e;

endpackage

// File: rtl/ialu_addsub.sv
module ialu_addsub #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] y_o
);
    // Two's-complement subtract: invert b and inject the carry-in.
    logic [WIDTH-1:0] b_eff;

    assign b_eff = b_i ^ {WIDTH{sub_i}};
    assign y_o   = a_i + b_eff + WIDTH'(sub_i);
endmodule

// File: rtl/ialu_logic.sv
module ialu_logic
    import ialu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic_fn_e        fn_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        unique case (fn_i)
            LF_AND:  y_o = a_i & b_i;
            LF_OR:   y_o = a_i | b_i;
            LF_XOR:  y_o = a_i ^ b_i;
            default: y_o = ~(a_i | b_i);
        endcase
    end
endmodule

// File: rtl/ialu_shift.sv
module ialu_shift
    import ialu_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter int unsigned SHAMT_W = 5
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [SHAMT_W-1:0] cnt_i,
    input  shift_kind_e        kind_i,
    output logic [WIDTH-1:0]   y_o
);
    // Complement distance; equals WIDTH for a zero count, where the
    // opposite shift yields all zeros and the rotate returns a unchanged.
    logic [SHAMT_W:0]  back;
    logic [WIDTH-1:0]  shl;
    logic [WIDTH-1:0]  shr;
    logic [WIDTH-1:0]  sra;

    assign back = (SHAMT_W+1)'(WIDTH) - {1'b0, cnt_i};
    assign shl  = a_i << cnt_i;
    assign shr  = a_i >> cnt_i;
    assign sra  = $signed(a_i) >>> cnt_i;

    always_comb begin
        unique case (kind_i)
            SK_SLL:  y_o = shl;
            SK_SRL:  y_o = shr;
            SK_SRA:  y_o = sra;
            SK_ROL:  y_o = shl | (a_i >> back);
            SK_ROR:  y_o = shr | (a_i << back);
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/ialu_cmp.sv
module ialu_cmp #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             eq_o,
    output logic             lt_s_o,
    output logic             lt_u_o
);
    assign eq_o   = (a_i == b_i);
    assign lt_s_o = ($signed(a_i) < $signed(b_i));
    assign lt_u_o = (a_i < b_i);
endmodule

// File: rtl/ialu_mul.sv
module ialu_mul #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             a_signed_i,
    input  logic             b_signed_i,
    output logic [WIDTH-1:0] lo_o,
    output logic [WIDTH-1:0] hi_o
);
    localparam int unsigned PW = 2 * WIDTH;

    // One shared multiplier: operands widened to the product width with
    // sign or zero fill, product taken modulo 2^PW.
    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] prod;

    assign a_ext = {{WIDTH{a_signed_i & a_i[WIDTH-1]}}, a_i};
    assign b_ext = {{WIDTH{b_signed_i & b_i[WIDTH-1]}}, b_i};
    assign prod  = a_ext * b_ext;
    assign lo_o  = prod[WIDTH-1:0];
    assign hi_o  = prod[PW-1:WIDTH];
endmodule

// File: rtl/ialu_core.sv
module ialu_core
    import ialu_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned SHAMT_W = $clog2(WIDTH),
    parameter bit          OUT_REG = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [5:0]         op_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic [IMM_W-1:0]   imm16_i,
    input  logic [SHAMT_W-1:0] imm5_i,
    output logic [WIDTH-1:0]   result_o
);
    localparam int unsigned PAD_W = WIDTH - IMM_W;

    typedef struct packed {
        logic [WIDTH-1:0] result;
    } state_t;

    state_t st_d;
    state_t st_q;

    alu_op_e            op;
    logic [WIDTH-1:0]   imm_sx;
    logic [WIDTH-1:0]   imm_zx;
    logic [WIDTH-1:0]   imm_hi;

    logic [WIDTH-1:0]   opnd_b;
    logic               do_sub;
    logic_fn_e          lfn;
    shift_kind_e        skind;
    logic [SHAMT_W-1:0] cnt;
    logic               mul_as;
    logic               mul_bs;

    logic [WIDTH-1:0]   sum_y;
    logic [WIDTH-1:0]   logic_y;
    logic [WIDTH-1:0]   shift_y;
    logic               c_eq;
    logic               c_lt_s;
    logic               c_lt_u;
    logic [WIDTH-1:0]   mul_lo;
    logic [WIDTH-1:0]   mul_hi;

    assign op     = alu_op_e'(op_i);
    assign imm_sx = {{PAD_W{imm16_i[IMM_W-1]}}, imm16_i};
    assign imm_zx = {{PAD_W{1'b0}}, imm16_i};
    assign imm_hi = {imm16_i, {PAD_W{1'b0}}};

    // Operand routing: picks the second operand and the unit controls.
    always_comb begin
        opnd_b = b_i;
        do_sub = 1'b0;
        lfn    = LF_AND;
        skind  = SK_SLL;
        cnt    = b_i[SHAMT_W-1:0];
        mul_as = 1'b0;
        mul_bs = 1'b0;
        unique case (op)
            OP_ADDI:   opnd_b = imm_sx;
            OP_SUB:    do_sub = 1'b1;
            OP_SUBI: begin
                opnd_b = imm_sx;
                do_sub = 1'b1;
            end
            OP_AND:    lfn = LF_AND;
            OP_ANDI: begin
                opnd_b = imm_zx;
                lfn    = LF_AND;
            end
            OP_ANDHI: begin
                opnd_b = imm_hi;
                lfn    = LF_AND;
            end
            OP_OR:     lfn = LF_OR;
            OP_ORI: begin
                opnd_b = imm_zx;
                lfn    = LF_OR;
            end
            OP_ORHI: begin
                opnd_b = imm_hi;
                lfn    = LF_OR;
            end
            OP_XOR:    lfn = LF_XOR;
            OP_XORI: begin
                opnd_b = imm_zx;
                lfn    = LF_XOR;
            end
            OP_XORHI: begin
                opnd_b = imm_hi;
                lfn    = LF_XOR;
            end
            OP_NOR:    lfn = LF_NOR;
            OP_ROL:    skind = SK_ROL;
            OP_ROLI: begin
                skind = SK_ROL;
                cnt   = imm5_i;
            end
            OP_ROR:    skind = SK_ROR;
            OP_SLL:    skind = SK_SLL;
            OP_SLLI: begin
                skind = SK_SLL;
                cnt   = imm5_i;
            end
            OP_SRL:    skind = SK_SRL;
            OP_SRLI: begin
                skind = SK_SRL;
                cnt   = imm5_i;
            end
            OP_SRA:    skind = SK_SRA;
            OP_SRAI: begin
                skind = SK_SRA;
                cnt   = imm5_i;
            end
            OP_CMPEQI, OP_CMPNEI, OP_CMPGEI, OP_CMPLTI: opnd_b = imm_sx;
            OP_CMPGEUI, OP_CMPLTUI:                     opnd_b = imm_zx;
            OP_MULI:   opnd_b = imm_sx;
            OP_MULHSS: begin
                mul_as = 1'b1;
                mul_bs = 1'b1;
            end
            OP_MULHSU: mul_as = 1'b1;
            default: ;
        endcase
    end

    ialu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i   (a_i),
        .b_i   (opnd_b),
        .sub_i (do_sub),
        .y_o   (sum_y)
    );

    ialu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i  (a_i),
        .b_i  (opnd_b),
        .fn_i (lfn),
        .y_o  (logic_y)
    );

    ialu_shift #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shift (
        .a_i    (a_i),
        .cnt_i  (cnt),
        .kind_i (skind),
        .y_o    (shift_y)
    );

    ialu_cmp #(.WIDTH(WIDTH)) u_cmp (
        .a_i    (a_i),
        .b_i    (opnd_b),
        .eq_o   (c_eq),
        .lt_s_o (c_lt_s),
        .lt_u_o (c_lt_u)
    );

    ialu_mul #(.WIDTH(WIDTH)) u_mul (
        .a_i        (a_i),
        .b_i        (opnd_b),
        .a_signed_i (mul_as),
        .b_signed_i (mul_bs),
        .lo_o       (mul_lo),
        .hi_o       (mul_hi)
    );

    // Next-state: result selection by operation family.
    always_comb begin
        st_d.result = '0;
        unique case (op)
            OP_ADD, OP_ADDI, OP_SUB, OP_SUBI:
                st_d.result = sum_y;
            OP_AND, OP_ANDI, OP_ANDHI, OP_OR, OP_ORI, OP_ORHI,
            OP_XOR, OP_XORI, OP_XORHI, OP_NOR:
                st_d.result = logic_y;
            OP_ROL, OP_ROLI, OP_ROR, OP_SLL, OP_SLLI,
            OP_SRL, OP_SRLI, OP_SRA, OP_SRAI:
                st_d.result = shift_y;
            OP_CMPEQ, OP_CMPEQI:   st_d.result = WIDTH'(c_eq);
            OP_CMPNE, OP_CMPNEI:   st_d.result = WIDTH'(!c_eq);
            OP_CMPGE, OP_CMPGEI:   st_d.result = WIDTH'(!c_lt_s);
            OP_CMPGEU, OP_CMPGEUI: st_d.result = WIDTH'(!c_lt_u);
            OP_CMPLT, OP_CMPLTI:   st_d.result = WIDTH'(c_lt_s);
            OP_CMPLTU, OP_CMPLTUI: st_d.result = WIDTH'(c_lt_u);
            OP_MUL, OP_MULI:       st_d.result = mul_lo;
            OP_MULHSS, OP_MULHSU, OP_MULHUU:
                st_d.result = mul_hi;
            default:               st_d.result = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (OUT_REG) begin : g_reg_out
            assign result_o = st_q.result;
        end else begin : g_comb_out
            assign result_o = st_d.result;
        end
    endgenerate

endmodule

// File: rtl/ialu_core_chk.sv
module ialu_core_chk
    import ialu_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned SHAMT_W = 5,
    parameter bit          OUT_REG = 1'b1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [5:0]         op_i,
    input logic [WIDTH-1:0]   a_i,
    input logic [WIDTH-1:0]   b_i,
    input logic [IMM_W-1:0]   imm16_i,
    input logic [SHAMT_W-1:0] imm5_i,
    input logic [WIDTH-1:0]   result_o
);
    localparam int unsigned PAD_W = WIDTH - IMM_W;

    logic is_cmp;
    assign is_cmp = (op_i >= OP_CMPEQ) && (op_i <= OP_CMPLTUI);

    generate
        if (OUT_REG) begin : g_props
            AST_RESET_ZERO: assert property (@(posedge clk_i)
                !rst_ni |=> (result_o == '0)); // R1

            AST_SUB_SELF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_i == OP_SUB) && (a_i == b_i) |=> (result_o == '0)); // R2

            AST_ADDI_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_i == OP_ADDI) && (a_i == '0)
                |=> (result_o == {{PAD_W{$past(imm16_i[IMM_W-1])}}, $past(imm16_i)})); // R2

            AST_HI_KEEPS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_i == OP_ORHI) |=> (result_o[PAD_W-1:0] == $past(a_i[PAD_W-1:0]))); // R4

            AST_ROL_ZERO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_i == OP_ROL) && (b_i[SHAMT_W-1:0] == '0) |=> (result_o == $past(a_i))); // R6

            AST_SRA_FULL_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_i == OP_SRAI) && (imm5_i == SHAMT_W'(WIDTH-1))
                |=> (result_o == {WIDTH{$past(a_i[WIDTH-1])}})); // R7

            AST_CMP_IS_BOOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
                is_cmp |=> (result_o[WIDTH-1:1] == '0)); // R8

            AST_EQ_SELF_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_i == OP_CMPEQ) && (a_i == b_i) |=> (result_o == WIDTH'(1))); // R8

            AST_MUL_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_i == OP_MUL) && (b_i == WIDTH'(1)) |=> (result_o == $past(a_i))); // R10

            AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_i >= 6'(OP_CODES_USED)) |=> (result_o == '0)); // R12
        end
    endgenerate
endmodule

bind ialu_core ialu_core_chk #(
    .WIDTH   (WIDTH),
    .IMM_W   (IMM_W),
    .SHAMT_W (SHAMT_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .imm16_i  (imm16_i),
    .imm5_i   (imm5_i),
    .result_o (result_o)
);

// File: tb/ialu_core_test.sv
module ialu_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op = 6'h3F;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [15:0] i16 = '0;
    logic [4:0]  i5 = '0;
    logic [31:0] res;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ialu_core uut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .imm16_i  (i16),
        .imm5_i   (i5),
        .result_o (res)
    );

    localparam logic [31:0] CORNERS [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF,
                                            32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678};
    localparam logic [15:0] ICORN [5] = '{16'h0000, 16'h7000, 16'h8000, 16'hFFFF, 16'h7FFF};

    function automatic logic [31:0] rot_l(input logic [31:0] v, input int n);
        logic [31:0] r = v;
        for (int k = 0; k < n; k++) r = {r[30:0], r[31]};
        return r;
    endfunction

    function automatic logic [31:0] rot_r(input logic [31:0] v, input int n);
        logic [31:0] r = v;
        for (int k = 0; k < n; k++) r = {r[0], r[31:1]};
        return r;
    endfunction

    function automatic logic [31:0] sh_ar(input logic [31:0] v, input int n);
        logic [31:0] r = v;
        for (int k = 0; k < n; k++) r = {r[31], r[31:1]};
        return r;
    endfunction

    function automatic logic [31:0] model(input int code, input logic [31:0] x,
                                          input logic [31:0] y, input logic [15:0] im,
                                          input logic [4:0] c5);
        logic [31:0] sx = {{16{im[15]}}, im};
        logic [31:0] zx = {16'h0, im};
        logic [31:0] hx = {im, 16'h0};
        int          n  = int'(y[4:0]);
        longint      sa = longint'($signed(x));
        longint      sb = longint'($signed(y));
        longint      ua = longint'({32'h0, x});
        longint      ub = longint'({32'h0, y});
        longint      p;
        case (code)
            0:  return x + y;
            1:  return x + sx;
            2:  return x - y;
            3:  return x - sx;
            4:  return x & y;
            5:  return x & zx;
            6:  return x & hx;
            7:  return x | y;
            8:  return x | zx;
            9:  return x | hx;
            10: return x ^ y;
            11: return x ^ zx;
            12: return x ^ hx;
            13: return ~(x | y);
            14: return rot_l(x, n);
            15: return rot_l(x, int'(c5));
            16: return rot_r(x, n);
            17: return x << n;
            18: return x << c5;
            19: return x >> n;
            20: return x >> c5;
            21: return sh_ar(x, n);
            22: return sh_ar(x, int'(c5));
            23: return {31'h0, x == y};
            24: return {31'h0, x == sx};
            25: return {31'h0, x != y};
            26: return {31'h0, x != sx};
            27: return {31'h0, $signed(x) >= $signed(y)};
            28: return {31'h0, $signed(x) >= $signed(sx)};
            29: return {31'h0, x >= y};
            30: return {31'h0, x >= zx};
            31: return {31'h0, $signed(x) < $signed(y)};
            32: return {31'h0, $signed(x) < $signed(sx)};
            33: return {31'h0, x < y};
            34: return {31'h0, x < zx};
            35: begin p = sa * sb; return p[31:0]; end
            36: begin p = sa * longint'($signed(sx)); return p[31:0]; end
            37: begin p = sa * sb; return p[63:32]; end
            38: begin p = sa * ub; return p[63:32]; end
            39: begin p = ua * ub; return p[63:32]; end
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
        end
    endtask

    // One operation: drive on a falling edge, read one falling edge later.
    task automatic run_op(input string req, input int code, input logic [31:0] x,
                          input logic [31:0] y, input logic [15:0] im, input logic [4:0] c5);
        @(negedge clk);
        op  = 6'(code);
        a   = x;
        b   = y;
        i16 = im;
        i5  = c5;
        @(negedge clk);
        check(req, $sformatf("op %0d a=%08h b=%08h imm=%04h c=%0d", code, x, y, im, c5),
              res, model(code, x, y, im, c5));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "result during reset", res, 32'h0);
        op = 6'h00; a = 32'h5; b = 32'h6;
        @(negedge clk);
        check("R1", "reset holds result", res, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "first result after release", res, 32'hB);
        @(posedge clk);
        #1;
        check("R1", "result stable within cycle", res, 32'hB);
    endtask

    task automatic t_arith;
        foreach (CORNERS[i]) foreach (CORNERS[j]) begin
            run_op("R2", 0, CORNERS[i], CORNERS[j], 16'h0, 5'd0);
            run_op("R2", 2, CORNERS[i], CORNERS[j], 16'h0, 5'd0);
        end
        foreach (ICORN[k]) begin
            run_op("R2", 1, 32'h0000_1000, 32'h0, ICORN[k], 5'd0);
            run_op("R2", 3, 32'h0000_1000, 32'h0, ICORN[k], 5'd0);
        end
        run_op("R2", 1, 32'h0, 32'h0, 16'h8000, 5'd0);
        check("R2", "addi 0x8000 sign-extends", res, 32'hFFFF_8000);
        run_op("R2", 1, 32'h0, 32'h0, 16'h7000, 5'd0);
        check("R2", "addi 0x7000 zero upper", res, 32'h0000_7000);
        run_op("R2", 0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        check("R2", "add wraps", res, 32'h0);
    endtask

    task automatic t_logic;
        foreach (CORNERS[i]) foreach (CORNERS[j]) begin
            run_op("R3", 4, CORNERS[i], CORNERS[j], 16'h0, 5'd0);
            run_op("R3", 7, CORNERS[i], CORNERS[j], 16'h0, 5'd0);
            run_op("R3", 10, CORNERS[i], CORNERS[j], 16'h0, 5'd0);
            run_op("R3", 13, CORNERS[i], CORNERS[j], 16'h0, 5'd0);
        end
        foreach (ICORN[k]) begin
            run_op("R3", 5, 32'hFFFF_FFFF, 32'h0, ICORN[k], 5'd0);
            run_op("R3", 8, 32'h0000_0000, 32'h0, ICORN[k], 5'd0);
            run_op("R3", 11, 32'hA5A5_A5A5, 32'h0, ICORN[k], 5'd0);
            run_op("R4", 6, 32'hFFFF_FFFF, 32'h0, ICORN[k], 5'd0);
            run_op("R4", 9, 32'h0000_1234, 32'h0, ICORN[k], 5'd0);
            run_op("R4", 12, 32'hA5A5_A5A5, 32'h0, ICORN[k], 5'd0);
        end
        run_op("R3", 8, 32'h0, 32'h0, 16'h8000, 5'd0);
        check("R3", "ori zero-extends", res, 32'h0000_8000);
        run_op("R4", 9, 32'h0000_0001, 32'h0, 16'h8000, 5'd0);
        check("R4", "orhi places upper half", res, 32'h8000_0001);
    endtask

    task automatic t_shift;
        for (int n = 0; n < 32; n++) begin
            run_op("R6", 14, 32'h8123_4567, 32'(n), 16'h0, 5'd0);
            run_op("R6", 15, 32'h8123_4567, 32'h0, 16'h0, 5'(n));
            run_op("R6", 16, 32'h8123_4567, 32'(n), 16'h0, 5'd0);
            run_op("R7", 17, 32'h8123_4567, 32'(n), 16'h0, 5'd0);
            run_op("R7", 18, 32'hF00F_000F, 32'h0, 16'h0, 5'(n));
            run_op("R7", 19, 32'h8123_4567, 32'(n), 16'h0, 5'd0);
            run_op("R7", 20, 32'hF00F_000F, 32'h0, 16'h0, 5'(n));
            run_op("R7", 21, 32'h8123_4567, 32'(n), 16'h0, 5'd0);
            run_op("R7", 22, 32'h4123_4567, 32'h0, 16'h0, 5'(n));
        end
        run_op("R6", 16, 32'h0000_0001, 32'd1, 16'h0, 5'd0);
        check("R6", "ror 1 wraps low bit to top", res, 32'h8000_0000);
        run_op("R6", 15, 32'h0000_0001, 32'h0, 16'h0, 5'd31);
        check("R6", "roli 32-1 equals ror 1", res, 32'h8000_0000);
        run_op("R5", 17, 32'h0000_0001, 32'hFFFF_FFE3, 16'h0, 5'd0);
        check("R5", "sll ignores b[31:5]", res, 32'h0000_0008);
        run_op("R5", 21, 32'h8000_0000, 32'h0000_0024, 16'h0, 5'd0);
        check("R5", "sra count 0x24 uses 4", res, 32'hF800_0000);
        run_op("R5", 14, 32'h1234_5678, 32'hFFFF_FFE0, 16'h0, 5'd0);
        check("R5", "rol by 32 is no rotate", res, 32'h1234_5678);
        run_op("R7", 22, 32'h8000_0000, 32'h0, 16'h0, 5'd31);
        check("R7", "srai fills with sign", res, 32'hFFFF_FFFF);
    endtask

    task automatic t_compare;
        foreach (CORNERS[i]) foreach (CORNERS[j]) begin
            for (int c = 23; c <= 33; c += 2)
                run_op("R8", c, CORNERS[i], CORNERS[j], 16'h0, 5'd0);
        end
        foreach (CORNERS[i]) foreach (ICORN[k]) begin
            for (int c = 24; c <= 34; c += 2)
                run_op("R9", c, CORNERS[i], 32'h0, ICORN[k], 5'd0);
        end
        run_op("R8", 31, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        check("R8", "signed -1 < 1", res, 32'h1);
        run_op("R8", 33, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        check("R8", "unsigned max not < 1", res, 32'h0);
        run_op("R9", 24, 32'hFFFF_8000, 32'h0, 16'h8000, 5'd0);
        check("R9", "cmpeqi sign-extends", res, 32'h1);
        run_op("R9", 34, 32'h0000_7FFF, 32'h0, 16'h8000, 5'd0);
        check("R9", "cmpltui zero-extends", res, 32'h1);
    endtask

    task automatic t_mul;
        foreach (CORNERS[i]) foreach (CORNERS[j]) begin
            run_op("R10", 35, CORNERS[i], CORNERS[j], 16'h0, 5'd0);
            run_op("R11", 37, CORNERS[i], CORNERS[j], 16'h0, 5'd0);
            run_op("R11", 38, CORNERS[i], CORNERS[j], 16'h0, 5'd0);
            run_op("R11", 39, CORNERS[i], CORNERS[j], 16'h0, 5'd0);
        end
        foreach (ICORN[k]) run_op("R10", 36, 32'h0001_0003, 32'h0, ICORN[k], 5'd0);
        run_op("R11", 37, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0);
        check("R11", "ss -1*-1 high word", res, 32'h0);
        run_op("R11", 38, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0);
        check("R11", "su -1*max high word", res, 32'hFFFF_FFFF);
        run_op("R11", 39, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0);
        check("R11", "uu max*max high word", res, 32'hFFFF_FFFE);
        run_op("R10", 36, 32'h0000_0002, 32'h0, 16'hFFFF, 5'd0);
        check("R10", "muli by -1 sign-extended", res, 32'hFFFF_FFFE);
    endtask

    task automatic t_unused;
        for (int c = 40; c < 64; c++) begin
            run_op("R12", c, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31);
            check("R12", $sformatf("unused code %0d is zero", c), res, 32'h0);
        end
    endtask

    task automatic t_random;
        for (int k = 0; k < 3000; k++) begin
            int c = int'($urandom_range(0, 39));
            string tag;
            tag = (c <= 3) ? "R2" : (c == 6 || c == 9 || c == 12) ? "R4" :
                  (c <= 13) ? "R3" : (c <= 16) ? "R6" : (c <= 22) ? "R7" :
                  (c <= 34) ? ((c % 2 == 1) ? "R8" : "R9") :
                  (c <= 36) ? "R10" : "R11";
            run_op(tag, c, $urandom, $urandom, 16'($urandom), 5'($urandom));
        end
    endtask

    initial begin
        t_reset();
        t_arith();
        t_logic();
        t_shift();
        t_compare();
        t_mul();
        t_unused();
        t_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule